// File: doc/BRIEF.md
# Radix MMU Root-Pointer Cache

This block is the front end of a radix-tree address translator. It holds two cached process-table entries. One belongs to process index 0 and serves the upper half of the address space. The other belongs to the current process identifier and serves the lower half. For each translation request, the block picks the page-table root using the most significant address bit. It also rejects addresses that fall in the two unmapped quadrants or above the range the tree covers. When the needed entry is not cached, it issues a refill read into the process table and answers once the data returns.

The same block owns the process-identifier and table-base registers. Writing either register drops the cached entries that the write makes stale and pulses a full TLB flush. TLB invalidate requests are turned into either a full-flush strobe or a single-entry flush strobe. A RIC value of 2 also empties both cached entries. The tree walker sits downstream and consumes the root and the segment-error response.

Top module: `radix_root_cache`

## Requirements
- R1: After reset, `rsp_valid`, `fill_req`, `tlb_flush_all` and `tlb_flush_one` are 0, `req_ready` is 1, and both cached entries are invalid.
- R2: An accepted request whose address bits [63:62] are 01 or 10 gives `rsp_valid`=1 with `rsp_seg_err`=1 and `rsp_root`=0 on the cycle after acceptance. No refill is issued.
- R3: Address bit 63 selects the cached entry. A value of 1 uses entry index 0, and a value of 0 uses the entry indexed by PID. A refill reads at `fill_addr` = table base + index*16.
- R4: An accepted in-quadrant request that finds a valid entry responds on the next cycle. `rsp_root` is the entry with bits [4:0] cleared.
- R5: Bits [4:0] of an entry are a size field s. The address is out of range when any address bit from 31+s up to bit 61 is 1. An out-of-range address gets `rsp_seg_err`=1 and `rsp_root`=0.
- R6: When the selected entry is invalid, `fill_req` pulses on the cycle after acceptance. The response appears on the cycle after `fill_valid`, computed from `fill_data`. The entry then becomes valid, so the next request to it hits.
- R7: A write to the table-base register (`spr_wr_sel`=1), or an invalidate with `inv_ric`=2, invalidates both cached entries.
- R8: A write to the PID register (`spr_wr_sel`=0) invalidates only the PID-indexed entry. Entry 0 stays cached.
- R9: Every register write pulses `tlb_flush_all` for one cycle, on the cycle after the write.
- R10: An invalidate request pulses `tlb_flush_all` when `inv_is` or `inv_ap` is nonzero, and `tlb_flush_one` otherwise, on the next cycle.
- R11: If the entry being refilled is invalidated while the refill is pending, the response still comes from `fill_data`, but the entry is left invalid.
- R12: `req_ready` is 0 from the cycle `fill_req` pulses until the refill data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_wr_en | input | 1 | Register write strobe |
| spr_wr_sel | input | 1 | 0 = PID register, 1 = table-base register |
| spr_wr_data | input | 64 | Register write data |
| inv_valid | input | 1 | TLB invalidate strobe |
| inv_ric | input | 2 | Invalidate control; 2 drops both cached entries |
| inv_is | input | 2 | Invalidate scope; nonzero means full flush |
| inv_ap | input | 3 | Page-size code; nonzero means full flush |
| req_valid | input | 1 | Translation request |
| req_addr | input | 64 | Effective address |
| req_ready | output | 1 | Request can be accepted |
| fill_req | output | 1 | Refill read strobe |
| fill_addr | output | 64 | Refill read address |
| fill_valid | input | 1 | Refill data return |
| fill_data | input | 64 | Returned process-table entry |
| rsp_valid | output | 1 | Response strobe |
| rsp_seg_err | output | 1 | Segment error (quadrant or range) |
| rsp_root | output | 64 | Selected root pointer |
| tlb_flush_all | output | 1 | Flush every TLB entry |
| tlb_flush_one | output | 1 | Flush one TLB entry |

## Verification
Every result here is a single register stage away from its cause. A response, a segment error, a refill request or a flush strobe appears one edge after the stimulus, and a refill response one edge after `fill_valid`. The bench drives each stimulus on a falling edge for one cycle, then samples at the next falling edge, exactly one rising edge later. When a refill is pending, it also checks `req_ready` and only then returns the data. Operations are serialized so that the reference model changes state at the same points as the design.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} rpc_state_t;
  localparam int SLOT_PID  = 0;
  localparam int SLOT_ZERO = 1;
  localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/rpc_slot_store.sv
module rpc_slot_store #(
  parameter int W = 64,
  parameter int N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      inv_mask,
  input  logic              wr_en,
  input  logic              wr_slot,
  input  logic [W-1:0]      wr_data,
  output logic [N-1:0][W-1:0] ent,
  output logic [N-1:0]      vld
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i] <= 1'b0;
        ent[i] <= '0;
      end else begin
        if (wr_en && (int'(wr_slot) == i)) ent[i] <= wr_data;
        if (inv_mask[i]) vld[i] <= 1'b0;
        else if (wr_en && (int'(wr_slot) == i)) vld[i] <= 1'b1;
      end
    end

    // R7 R8
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
      inv_mask[i] |=> !vld[i]);
  end
endmodule

// File: rtl/rpc_range_chk.sv
module rpc_range_chk #(
  parameter int LOW_W     = 62,
  parameter int BASE_BITS = 31,
  parameter int SIZE_W    = 5
) (
  input  logic [LOW_W-1:0]  addr,
  input  logic [SIZE_W-1:0] size,
  output logic              out_of_range
);
  int limit;
  always_comb begin
    limit = BASE_BITS + int'(size);
    out_of_range = 1'b0;
    for (int i = 0; i < LOW_W; i++) begin
      if (i >= limit && addr[i]) out_of_range = 1'b1;
    end
  end
endmodule

// File: rtl/rpc_flush_gen.sv
module rpc_flush_gen #(
  parameter int IS_W = 2,
  parameter int AP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spr_wr_en,
  input  logic            inv_valid,
  input  logic [IS_W-1:0] inv_is,
  input  logic [AP_W-1:0] inv_ap,
  output logic            flush_all,
  output logic            flush_one
);
  logic wide;
  assign wide = (inv_is != '0) || (inv_ap != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_all <= 1'b0;
      flush_one <= 1'b0;
    end else begin
      flush_all <= spr_wr_en || (inv_valid && wide);
      flush_one <= inv_valid && !wide && !spr_wr_en;
    end
  end

  // R9
  spr_flush_chk: assert property (@(posedge clk) disable iff (rst)
    spr_wr_en |=> flush_all);
  // R10
  narrow_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_is == '0 && inv_ap == '0 && !spr_wr_en) |=> (flush_one && !flush_all));
endmodule

// File: rtl/radix_root_cache.sv
module radix_root_cache #(
  parameter int AW        = 64,
  parameter int PID_W     = 20,
  parameter int ENT_LOG2  = 4,
  parameter int BASE_BITS = 31,
  parameter int SIZE_W    = 5,
  parameter int RIC_W     = 2,
  parameter int IS_W      = 2,
  parameter int AP_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spr_wr_en,
  input  logic            spr_wr_sel,
  input  logic [AW-1:0]   spr_wr_data,
  input  logic            inv_valid,
  input  logic [RIC_W-1:0] inv_ric,
  input  logic [IS_W-1:0] inv_is,
  input  logic [AP_W-1:0] inv_ap,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ready,
  output logic            fill_req,
  output logic [AW-1:0]   fill_addr,
  input  logic            fill_valid,
  input  logic [AW-1:0]   fill_data,
  output logic            rsp_valid,
  output logic            rsp_seg_err,
  output logic [AW-1:0]   rsp_root,
  output logic            tlb_flush_all,
  output logic            tlb_flush_one
);
  import rpc_pkg::*;

  localparam int LOW_W = AW - 2;
  localparam logic [RIC_W-1:0] RIC_ALL = RIC_W'(2);

  rpc_state_t           state;
  logic [PID_W-1:0]     pid_q;
  logic [AW-1:0]        base_q;
  logic [LOW_W-1:0]     hold_addr;
  logic                 hold_slot;
  logic                 kill_q;

  logic [NUM_SLOTS-1:0][AW-1:0] ent;
  logic [NUM_SLOTS-1:0] vld;
  logic [NUM_SLOTS-1:0] inv_mask;

  logic accept, quad_bad, req_slot, range_err, store_wr;
  logic [LOW_W-1:0]  chk_addr;
  logic [AW-1:0]     chk_ent;
  logic [PID_W-1:0]  fill_idx;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign quad_bad  = req_addr[AW-1] ^ req_addr[AW-2];
  assign req_slot  = req_addr[AW-1];

  always_comb begin
    inv_mask = '0;
    if ((spr_wr_en && spr_wr_sel) || (inv_valid && inv_ric == RIC_ALL))
      inv_mask = '1;
    else if (spr_wr_en && !spr_wr_sel)
      inv_mask[SLOT_PID] = 1'b1;
  end

  assign chk_addr = (state == ST_WAIT) ? hold_addr : req_addr[LOW_W-1:0];
  assign chk_ent  = (state == ST_WAIT) ? fill_data : ent[req_slot];
  assign fill_idx = req_slot ? '0 : pid_q;
  assign store_wr = (state == ST_WAIT) && fill_valid && !kill_q;

  rpc_range_chk #(.LOW_W(LOW_W), .BASE_BITS(BASE_BITS), .SIZE_W(SIZE_W)) u_range (
    .addr(chk_addr), .size(chk_ent[SIZE_W-1:0]), .out_of_range(range_err)
  );

  rpc_slot_store #(.W(AW), .N(NUM_SLOTS)) u_store (
    .clk(clk), .rst(rst), .inv_mask(inv_mask), .wr_en(store_wr),
    .wr_slot(hold_slot), .wr_data(fill_data), .ent(ent), .vld(vld)
  );

  rpc_flush_gen #(.IS_W(IS_W), .AP_W(AP_W)) u_flush (
    .clk(clk), .rst(rst), .spr_wr_en(spr_wr_en), .inv_valid(inv_valid),
    .inv_is(inv_is), .inv_ap(inv_ap), .flush_all(tlb_flush_all), .flush_one(tlb_flush_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q  <= '0;
      base_q <= '0;
    end else if (spr_wr_en) begin
      if (spr_wr_sel) base_q <= spr_wr_data;
      else            pid_q  <= spr_wr_data[PID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      hold_addr   <= '0;
      hold_slot   <= 1'b0;
      kill_q      <= 1'b0;
      fill_req    <= 1'b0;
      fill_addr   <= '0;
      rsp_valid   <= 1'b0;
      rsp_seg_err <= 1'b0;
      rsp_root    <= '0;
    end else begin
      fill_req  <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          hold_addr <= req_addr[LOW_W-1:0];
          hold_slot <= req_slot;
          if (quad_bad) begin
            rsp_valid   <= 1'b1;
            rsp_seg_err <= 1'b1;
            rsp_root    <= '0;
          end else if (vld[req_slot]) begin
            rsp_valid   <= 1'b1;
            rsp_seg_err <= range_err;
            rsp_root    <= range_err ? '0 : {chk_ent[AW-1:SIZE_W], {SIZE_W{1'b0}}};
          end else begin
            fill_req  <= 1'b1;
            fill_addr <= base_q + (AW'(fill_idx) << ENT_LOG2);
            kill_q    <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (inv_mask[hold_slot]) kill_q <= 1'b1;
          if (fill_valid) begin
            rsp_valid   <= 1'b1;
            rsp_seg_err <= range_err;
            rsp_root    <= range_err ? '0 : {chk_ent[AW-1:SIZE_W], {SIZE_W{1'b0}}};
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  quad_err_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && quad_bad) |=> (rsp_valid && rsp_seg_err && !fill_req));
  // R12
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> !req_ready);
  // R6
  fill_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> $past(req_valid));
  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fill_req));
endmodule

// File: tb/tb_radix_root_cache.sv
module tb_radix_root_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic spr_wr_en = 0, spr_wr_sel = 0;
  logic [63:0] spr_wr_data = '0;
  logic inv_valid = 0;
  logic [1:0] inv_ric = '0, inv_is = '0;
  logic [2:0] inv_ap = '0;
  logic req_valid = 0;
  logic [63:0] req_addr = '0;
  logic req_ready, fill_req, fill_valid = 0, rsp_valid, rsp_seg_err;
  logic [63:0] fill_addr, fill_data = '0, rsp_root;
  logic tlb_flush_all, tlb_flush_one;

  radix_root_cache dut (
    .clk(clk), .rst(rst), .spr_wr_en(spr_wr_en), .spr_wr_sel(spr_wr_sel),
    .spr_wr_data(spr_wr_data), .inv_valid(inv_valid), .inv_ric(inv_ric),
    .inv_is(inv_is), .inv_ap(inv_ap), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .rsp_valid(rsp_valid),
    .rsp_seg_err(rsp_seg_err), .rsp_root(rsp_root),
    .tlb_flush_all(tlb_flush_all), .tlb_flush_one(tlb_flush_one)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic m_vld [2];
  logic [63:0] m_ent [2];
  logic [19:0] m_pid;
  logic [63:0] m_base;

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic range_bad(logic [63:0] a, logic [63:0] e);
    int lim = 31 + int'(e[4:0]);
    for (int i = 0; i < 62; i++) if (i >= lim && a[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_spr(logic sel, logic [63:0] d);
    @(negedge clk);
    spr_wr_en = 1; spr_wr_sel = sel; spr_wr_data = d;
    @(negedge clk);
    spr_wr_en = 0;
    chk("R9 flush_all", 64'(tlb_flush_all), 64'd1);
    chk("R9 flush_one", 64'(tlb_flush_one), 64'd0);
    if (sel) begin m_base = d; m_vld[0] = 0; m_vld[1] = 0; end
    else begin m_pid = d[19:0]; m_vld[0] = 0; end
  endtask

  task automatic do_inv(logic [1:0] ric, logic [1:0] is_f, logic [2:0] ap);
    logic wide = (is_f != 0) || (ap != 0);
    @(negedge clk);
    inv_valid = 1; inv_ric = ric; inv_is = is_f; inv_ap = ap;
    @(negedge clk);
    inv_valid = 0;
    chk("R10 flush_all", 64'(tlb_flush_all), 64'(wide));
    chk("R10 flush_one", 64'(tlb_flush_one), 64'(!wide));
    if (ric == 2) begin m_vld[0] = 0; m_vld[1] = 0; end
  endtask

  task automatic expect_rsp(string req, logic [63:0] a, logic [63:0] e);
    logic bad = range_bad(a, e);
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " R5 seg_err"}, 64'(rsp_seg_err), 64'(bad));
    chk({req, " R4 root"}, rsp_root, bad ? 64'd0 : {e[63:5], 5'b0});
  endtask

  // kill: 0 none, 1 write PID during wait, 2 write base during wait
  task automatic do_req(logic [63:0] a, logic [63:0] fd, int kill);
    int s = int'(a[63]);
    logic [63:0] fa;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (a[63] != a[62]) begin
      chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R2 seg_err", 64'(rsp_seg_err), 64'd1);
      chk("R2 root", rsp_root, 64'd0);
      chk("R2 no fill", 64'(fill_req), 64'd0);
    end else if (m_vld[s]) begin
      chk("R6 no fill on hit", 64'(fill_req), 64'd0);
      expect_rsp("R4", a, m_ent[s]);
    end else begin
      fa = m_base + ((s == 1) ? 64'd0 : (64'(m_pid) << 4));
      chk("R6 fill_req", 64'(fill_req), 64'd1);
      chk("R3 fill_addr", fill_addr, fa);
      chk("R12 ready low", 64'(req_ready), 64'd0);
      if (kill == 1) begin
        spr_wr_en = 1; spr_wr_sel = 0; spr_wr_data = 64'(m_pid) + 1;
        @(negedge clk); spr_wr_en = 0; m_pid = m_pid + 1; m_vld[0] = 0;
      end else if (kill == 2) begin
        spr_wr_en = 1; spr_wr_sel = 1; spr_wr_data = m_base + 64'h1000;
        @(negedge clk); spr_wr_en = 0; m_base = m_base + 64'h1000;
        m_vld[0] = 0; m_vld[1] = 0;
      end
      chk("R12 ready still low", 64'(req_ready), 64'd0);
      fill_valid = 1; fill_data = fd;
      @(negedge clk);
      fill_valid = 0;
      expect_rsp("R6", a, fd);
      chk("R12 ready back", 64'(req_ready), 64'd1);
      if (kill == 0 || (kill == 1 && s == 1)) begin
        m_vld[s] = 1; m_ent[s] = fd;
      end
    end
  endtask

  function automatic logic [63:0] rnd_addr(int quad);
    logic [63:0] a = {$urandom, $urandom};
    int keep = 28 + int'($urandom % 12);
    a = a & ((64'd1 << keep) - 1);
    if (($urandom % 4) == 0) a[40 + ($urandom % 22)] = 1'b1;
    a[63:62] = 2'(quad);
    return a;
  endfunction

  function automatic logic [63:0] rnd_ent();
    logic [63:0] e = {$urandom, $urandom};
    e[4:0] = 5'($urandom % 12);
    return e;
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_vld[0] = 0; m_vld[1] = 0; m_ent[0] = '0; m_ent[1] = '0;
    m_pid = '0; m_base = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 fill_req", 64'(fill_req), 64'd0);
    chk("R1 flush_all", 64'(tlb_flush_all), 64'd0);
    chk("R1 flush_one", 64'(tlb_flush_one), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);

    do_spr(1'b1, 64'h0000_0000_0010_0000);
    do_spr(1'b0, 64'd5);
    // R2 bad quadrants
    do_req(64'h4000_0000_0000_1000, 64'd0, 0);
    do_req(64'h8000_0000_0000_1000, 64'd0, 0);
    // R3 R6 refill into each slot, then hits
    do_req(64'hC000_0000_0000_2000, 64'h0000_0000_00AB_C003, 0);
    do_req(64'h0000_0000_1234_5000, 64'h0000_0000_00DE_F001, 0);
    do_req(64'hC000_0000_0000_3000, 64'd0, 0);
    do_req(64'h0000_0000_0000_7000, 64'd0, 0);
    // R5 range edge: size 3 -> bit 34 allowed? limit 34: bit 33 ok, bit 34 bad
    do_req(64'hC000_0002_0000_0000, 64'd0, 0);
    do_req(64'hC000_0004_0000_0000, 64'd0, 0);
    // R8 PID write keeps entry 0
    do_spr(1'b0, 64'd9);
    do_req(64'hC000_0000_0000_0100, 64'd0, 0);
    do_req(64'h0000_0000_0000_0100, 64'h0000_0000_0055_0000, 0);
    // R7 RIC=2 drops both; R10 narrow flush
    do_inv(2'd2, 2'd0, 3'd0);
    do_req(64'hC000_0000_0000_0200, 64'h0000_0000_0077_0002, 0);
    do_inv(2'd0, 2'd1, 3'd0);
    do_inv(2'd0, 2'd0, 3'd3);
    do_inv(2'd1, 2'd0, 3'd0);
    do_req(64'hC000_0000_0000_0300, 64'd0, 0);
    // R11 invalidate during pending refill
    do_req(64'h0000_0000_0000_0400, 64'h0000_0000_0099_0001, 1);
    do_req(64'h0000_0000_0000_0400, 64'h0000_0000_0099_0002, 0);
    do_spr(1'b1, 64'h0000_0000_0020_0000);
    do_req(64'hC000_0000_0000_0500, 64'h0000_0000_0011_0004, 2);
    do_req(64'hC000_0000_0000_0500, 64'h0000_0000_0011_0005, 0);

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 10);
      if (op == 0) do_spr(1'($urandom), {$urandom, $urandom} & 64'h0000_00FF_FFFF_F000);
      else if (op == 1) do_inv(2'($urandom), 2'($urandom % 2), 3'($urandom % 2));
      else do_req(rnd_addr(int'($urandom % 4)), rnd_ent(), 0);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule